// File: doc/BRIEF.md
# SRAM Subarray Access Sequencer

This block runs one access to an SRAM subarray over two clock cycles and produces the control strobes for it: the predecoded word-line enables, bit-line precharge, sense-amplifier precharge, the sense-enable pulse and the one-hot read and write column selects. Requests arrive on a valid/ready port that carries a read/write flag, a row, a column and write data. Read results leave on a valid-only port. The storage is a behavioural register array. Rows are decoded back from the predecoded lines and columns from the one-hot selects, so read data and write results follow from the strobes the sequencer drives.

The first cycle of an access is the development cycle. Bit-line precharge is released, the selected word line is on and the chosen column is connected. On a write, the data is driven into that column for the whole of the cycle. The second cycle is the sense cycle. The word line is off, the column selects drop so the sense amplifier is isolated, bit-line precharge returns, and on a read the sense enable fires. The sensed word appears on the result port in the cycle after that.

Back-pressure rules: `req_ready` is low only in the development cycle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the request must be held and has no effect. The result port has no ready input: `rd_valid` is a one-cycle pulse and the consumer must take it.

Top module: `sram_subarray_seq`

## Requirements
- R1: While reset is asserted and after it, with no request: req_ready=1, all predecode lines 0, bl_pre=1, sa_pre=1, sa_en=0, both column selects 0 and rd_valid=0.
- R2: req_ready is 0 in the development cycle, which follows the accepting edge, and 1 in every other cycle. A request held during that cycle is not taken until the next edge, so with requests always pending one is taken every second cycle.
- R3: In the development cycle the row is driven on GRP_BITS-wide groups. Row bits [2g+1:2g] set exactly one line, wl_pre[4g + field], in each group g. In every other cycle wl_pre is all zero.
- R4: bl_pre is 0 in the development cycle and 1 in all other cycles. It is never 1 while any predecode line is on, and it returns in the cycle after the word line drops.
- R5: In the development cycle of a read, rcol_sel has only bit [column] set. In the development cycle of a write, wcol_sel has only bit [column] set. Both are zero otherwise, and they are never both nonzero.
- R6: sa_en is 1 only in the sense cycle of a read, that is, directly after a full cycle with the word line on. A write never raises sa_en.
- R7: sa_pre is 0 in both cycles of a read and 1 otherwise, including both cycles of a write. It is therefore already 0 in the cycle before sa_en.
- R8: In the cycle after the sense cycle of a read, rd_valid is 1 for exactly one cycle and rd_data holds the word stored at (row, column). rd_valid is 0 after a write.
- R9: A write stores req_wdata at (row, column) at the end of its development cycle and leaves the other columns of that row unchanged. A read taken directly after the write returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W (8) | Row address |
| req_col | input | COL_W (3) | Column within each slice |
| req_wdata | input | WIDTH (8) | Write data, one bit per slice |
| wl_pre | output | PDEC_W (16) | Predecoded word-line groups, GRP_LINES lines per group |
| bl_pre | output | 1 | Bit-line precharge active |
| sa_pre | output | 1 | Sense-amplifier precharge active |
| sa_en | output | 1 | Sense-enable pulse |
| rcol_sel | output | COLS (8) | One-hot read column select |
| wcol_sel | output | COLS (8) | One-hot write column select |
| rd_valid | output | 1 | Read result valid, one-cycle pulse |
| rd_data | output | WIDTH (8) | Read result |

## Verification
The bench presents a new request while req_ready is low. A sequencer that took it would cut the sense cycle short and show the second request's word line where precharge should be back. It chains a read directly behind a write to the same location: an array that wrote late or a read path that sampled early returns the old word. The first random operations hit rows 0 and 255 and columns 0 and 7, where a predecode group built from the wrong bit field or offset lights the wrong line. It also mixes writes among reads, so a sense enable or a sense-amplifier precharge release during a write is caught cycle by cycle.

// File: rtl/sas_pkg.sv
package sas_pkg;
  // Phase of one two-cycle subarray access
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DEV   = 2'd1,   // word line on, bit-line signal develops
    PH_SENSE = 2'd2    // word line off, sense amplifier fires on reads
  } phase_e;
endpackage

// File: rtl/sas_ctrl.sv
module sas_ctrl
  import sas_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 3,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic [WIDTH-1:0] req_wdata_i,
  output logic             req_ready_o,
  output logic             wl_en_o,
  output logic             rcol_en_o,
  output logic             wcol_en_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic [WIDTH-1:0] wdata_o,
  output logic             bl_pre_o,
  output logic             sa_pre_o,
  output logic             sa_en_o
);
  phase_e           phase_q;
  logic             op_wr_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [WIDTH-1:0] wdata_q;
  logic             take;

  assign req_ready_o = (phase_q != PH_DEV);
  assign take        = req_valid_i && req_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_wr_q <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (take) begin
      phase_q <= PH_DEV;
      op_wr_q <= req_write_i;
      row_q   <= req_row_i;
      col_q   <= req_col_i;
      wdata_q <= req_wdata_i;
    end else begin
      case (phase_q)
        PH_DEV:  phase_q <= PH_SENSE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // Strobes decoded from the registered phase
  assign wl_en_o   = (phase_q == PH_DEV);
  assign rcol_en_o = wl_en_o && !op_wr_q;
  assign wcol_en_o = wl_en_o && op_wr_q;
  assign bl_pre_o  = (phase_q != PH_DEV);
  assign sa_pre_o  = (phase_q == PH_IDLE) || op_wr_q;
  assign sa_en_o   = (phase_q == PH_SENSE) && !op_wr_q;
  assign row_o     = row_q;
  assign col_o     = col_q;
  assign wdata_o   = wdata_q;

  // R2: an accepted request blocks the next edge
  p_accept_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready_o);

  // R6: every development cycle is followed by a sense cycle
  p_dev_then_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DEV) |=> (phase_q == PH_SENSE));
endmodule

// File: rtl/sas_row_predec.sv
module sas_row_predec #(
  parameter int ROW_W    = 8,
  parameter int GRP_BITS = 2,
  localparam int NGRP      = (ROW_W + GRP_BITS - 1) / GRP_BITS,
  localparam int GRP_LINES = 1 << GRP_BITS,
  localparam int PDEC_W    = NGRP * GRP_LINES,
  localparam int RPAD_W    = NGRP * GRP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [PDEC_W-1:0] pre_o
);
  logic [RPAD_W-1:0] row_pad;
  assign row_pad = RPAD_W'(row_i);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar l = 0; l < GRP_LINES; l++) begin : g_line
      assign pre_o[g*GRP_LINES + l] =
        en_i && (row_pad[g*GRP_BITS +: GRP_BITS] == GRP_BITS'(l));
    end

    // R3: with any line on, each group carries exactly one line
    p_group_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|pre_o) |-> ($countones(pre_o[g*GRP_LINES +: GRP_LINES]) == 1));
  end
endmodule

// File: rtl/sas_col_dec.sv
module sas_col_dec #(
  parameter int COLS = 8,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             en_i,
  input  logic [COL_W-1:0] col_i,
  output logic [COLS-1:0]  sel_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign sel_o[c] = en_i && (col_i == COL_W'(c));
  end
endmodule

// File: rtl/sas_array.sv
module sas_array #(
  parameter int ROWS     = 256,
  parameter int COLS     = 8,
  parameter int WIDTH    = 8,
  parameter int GRP_BITS = 2,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int NGRP      = (ROW_W + GRP_BITS - 1) / GRP_BITS,
  localparam int GRP_LINES = 1 << GRP_BITS,
  localparam int PDEC_W    = NGRP * GRP_LINES,
  localparam int RPAD_W    = NGRP * GRP_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PDEC_W-1:0] wl_pre_i,
  input  logic [COLS-1:0]   rcol_i,
  input  logic [COLS-1:0]   wcol_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              sa_en_i,
  output logic              rd_valid_o,
  output logic [WIDTH-1:0]  rd_data_o
);
  logic [COLS*WIDTH-1:0] mem [ROWS];
  logic [RPAD_W-1:0]     row_pad;
  logic [ROW_W-1:0]      row_idx;
  logic [COLS*WIDTH-1:0] row_word;
  logic [WIDTH-1:0]      col_mux;
  logic [WIDTH-1:0]      bl_q;
  logic [WIDTH-1:0]      sa_q;
  logic                  vld_q;

  // Row index rebuilt from the predecoded word-line groups
  always_comb begin
    row_pad = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int l = 0; l < GRP_LINES; l++) begin
        if (wl_pre_i[g*GRP_LINES + l]) row_pad[g*GRP_BITS +: GRP_BITS] = GRP_BITS'(l);
      end
    end
  end
  assign row_idx  = row_pad[ROW_W-1:0];
  assign row_word = mem[row_idx];

  always_comb begin
    col_mux = '0;
    for (int c = 0; c < COLS; c++) begin
      if (rcol_i[c]) col_mux = col_mux | row_word[c*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < COLS; c++) begin
      if (wcol_i[c]) mem[row_idx][c*WIDTH +: WIDTH] <= wdata_i;
    end
  end

  // Bit-line signal captured while the column is connected, latched by sense enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q  <= '0;
      sa_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (|rcol_i) bl_q <= col_mux;
      if (sa_en_i) sa_q <= bl_q;
      vld_q <= sa_en_i;
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = sa_q;

  // R9: a write drives a single column per slice
  p_write_one_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wcol_i));
endmodule

// File: rtl/sram_subarray_seq.sv
module sram_subarray_seq #(
  parameter int ROWS     = 256,
  parameter int COLS     = 8,
  parameter int WIDTH    = 8,
  parameter int GRP_BITS = 2,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int COL_W     = $clog2(COLS),
  localparam int NGRP      = (ROW_W + GRP_BITS - 1) / GRP_BITS,
  localparam int GRP_LINES = 1 << GRP_BITS,
  localparam int PDEC_W    = NGRP * GRP_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [WIDTH-1:0]  req_wdata,
  output logic [PDEC_W-1:0] wl_pre,
  output logic              bl_pre,
  output logic              sa_pre,
  output logic              sa_en,
  output logic [COLS-1:0]   rcol_sel,
  output logic [COLS-1:0]   wcol_sel,
  output logic              rd_valid,
  output logic [WIDTH-1:0]  rd_data
);
  logic             wl_en, rcol_en, wcol_en;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [WIDTH-1:0] wdata_q;

  sas_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_row_i(req_row), .req_col_i(req_col), .req_wdata_i(req_wdata),
    .req_ready_o(req_ready),
    .wl_en_o(wl_en), .rcol_en_o(rcol_en), .wcol_en_o(wcol_en),
    .row_o(row_q), .col_o(col_q), .wdata_o(wdata_q),
    .bl_pre_o(bl_pre), .sa_pre_o(sa_pre), .sa_en_o(sa_en)
  );

  sas_row_predec #(.ROW_W(ROW_W), .GRP_BITS(GRP_BITS)) u_rdec (
    .clk(clk), .rst_n(rst_n), .en_i(wl_en), .row_i(row_q), .pre_o(wl_pre)
  );

  sas_col_dec #(.COLS(COLS)) u_rcol (.en_i(rcol_en), .col_i(col_q), .sel_o(rcol_sel));
  sas_col_dec #(.COLS(COLS)) u_wcol (.en_i(wcol_en), .col_i(col_q), .sel_o(wcol_sel));

  sas_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .GRP_BITS(GRP_BITS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wl_pre_i(wl_pre), .rcol_i(rcol_sel), .wcol_i(wcol_sel),
    .wdata_i(wdata_q), .sa_en_i(sa_en),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  // R4: power race, precharge off whenever a word line is on
  p_pre_off_with_wl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|wl_pre) |-> !bl_pre);

  // R4: precharge is back in the cycle after the word line drops
  p_pre_back_after_wl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|wl_pre) |-> bl_pre);

  // R5: read and write column selects never overlap
  p_cols_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rcol_sel) && !((|rcol_sel) && (|wcol_sel)));

  // R6: functional race, sense only after a full cycle of word line on a read column
  p_sense_after_wl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sa_en |-> ($past(|wl_pre) && $past(|rcol_sel) && !(|wl_pre)));

  // R6: a write never triggers sense
  p_write_no_sense_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|wcol_sel) |=> !sa_en);

  // R7: sense-amplifier precharge released a cycle ahead of sense enable
  p_sapre_before_sense_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sa_en |-> (!sa_pre && $past(!sa_pre)));

  // R8: result follows the sense cycle of a read
  p_result_after_sense_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(sa_en) && $past(|rcol_sel, 2)));
endmodule

// File: tb/sram_subarray_seq_test.sv
module sram_subarray_seq_test;
  localparam int ROWS = 256, COLS = 8, WIDTH = 8, GRP_BITS = 2;
  localparam int ROW_W = 8, COL_W = 3, GRP_LINES = 4, NGRP = 4, PDEC_W = 16;
  localparam int WD_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [WIDTH-1:0]  req_wdata = '0;
  logic              req_ready, bl_pre, sa_pre, sa_en, rd_valid;
  logic [PDEC_W-1:0] wl_pre;
  logic [COLS-1:0]   rcol_sel, wcol_sel;
  logic [WIDTH-1:0]  rd_data;

  sram_subarray_seq #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .GRP_BITS(GRP_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .wl_pre(wl_pre), .bl_pre(bl_pre), .sa_pre(sa_pre), .sa_en(sa_en),
    .rcol_sel(rcol_sel), .wcol_sel(wcol_sel), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [WIDTH-1:0] ref_mem [ROWS][COLS];

  typedef struct {
    logic            wr;
    int              row;
    int              col;
    logic [WIDTH-1:0] d;
  } op_t;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PDEC_W-1:0] exp_pre(int row);
    logic [PDEC_W-1:0] v = '0;
    for (int g = 0; g < NGRP; g++) v[g*GRP_LINES + ((row >> (g*GRP_BITS)) & (GRP_LINES-1))] = 1'b1;
    return v;
  endfunction

  function automatic logic [COLS-1:0] oh(int c);
    logic [COLS-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  function automatic op_t mk_op(bit fill, int i);
    op_t o;
    o.d = WIDTH'($urandom);
    if (fill) begin
      o.wr = 1'b1; o.row = i / COLS; o.col = i % COLS;
    end else begin
      o.wr = 1'($urandom % 2);
      if (i < 4) begin
        o.row = (i & 1) ? ROWS-1 : 0;
        o.col = (i & 2) ? COLS-1 : 0;
      end else begin
        o.row = int'($urandom % ROWS);
        o.col = int'($urandom % COLS);
      end
    end
    return o;
  endfunction

  task automatic drive(input op_t o);
    req_valid = 1'b1;
    req_write = o.wr;
    req_row   = ROW_W'(o.row);
    req_col   = COL_W'(o.col);
    req_wdata = o.d;
  endtask

  task automatic check_p1(input op_t o);
    chk("R2 ready low in development cycle", req_ready, 0);
    chk("R3 predecoded word line", wl_pre, exp_pre(o.row));
    chk("R4 bit-line precharge released", bl_pre, 0);
    chk("R7 sense-amp precharge in development cycle", sa_pre, o.wr);
    chk("R6 no sense in development cycle", sa_en, 0);
    chk("R5 read column select", rcol_sel, o.wr ? '0 : oh(o.col));
    chk("R5 write column select", wcol_sel, o.wr ? oh(o.col) : '0);
  endtask

  task automatic check_p2(input op_t o);
    chk("R2 ready high in sense cycle", req_ready, 1);
    chk("R3 word line off in sense cycle", wl_pre, 0);
    chk("R4 precharge restored after word line", bl_pre, 1);
    chk("R6 sense enable only on reads", sa_en, !o.wr);
    chk("R7 sense-amp precharge in sense cycle", sa_pre, o.wr);
    chk("R5 column selects off in sense cycle", {rcol_sel, wcol_sel}, 0);
    chk("R8 no result during sense cycle", rd_valid, 0);
  endtask

  task automatic check_out(input logic rd, input logic [WIDTH-1:0] exp);
    chk("R8 result valid pulse", rd_valid, rd);
    if (rd) chk("R8 R9 read data", rd_data, exp);
  endtask

  task automatic check_idle();
    chk("R1 idle ready", req_ready, 1);
    chk("R1 idle word lines", wl_pre, 0);
    chk("R1 idle precharges", {bl_pre, sa_pre}, 2'b11);
    chk("R1 idle sense and columns", {sa_en, rcol_sel, wcol_sel}, 0);
  endtask

  task automatic run_ops(input int n, input bit fill);
    op_t cur;
    logic pv = 1'b0, prd = 1'b0;
    logic [WIDTH-1:0] pdat = '0;
    cur = mk_op(fill, 0);
    drive(cur);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check_p1(cur);
      if (pv) check_out(prd, pdat);
      req_valid = 1'b0;
      if (cur.wr) ref_mem[cur.row][cur.col] = cur.d;
      @(posedge clk); @(negedge clk);
      check_p2(cur);
      prd  = !cur.wr;
      pdat = ref_mem[cur.row][cur.col];
      if (i == n-1 || (!fill && ($urandom % 3 == 0))) begin
        @(posedge clk); @(negedge clk);
        check_out(prd, pdat);
        check_idle();
        pv = 1'b0;
        if (i != n-1) begin cur = mk_op(fill, i+1); drive(cur); end
      end else begin
        cur = mk_op(fill, i+1);
        drive(cur);   // presented in the sense cycle: taken back to back
        pv = 1'b1;
      end
    end
  endtask

  initial begin
    op_t a, b, c;
    logic [WIDTH-1:0] exp_a;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle();                       // R1 under reset
    chk("R1 no result under reset", rd_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_idle();                       // R1 after reset, no request
    chk("R1 no result after reset", rd_valid, 0);

    run_ops(ROWS*COLS, 1'b1);           // fill every location, chained writes
    run_ops(400, 1'b0);                 // random mix with corner addresses first

    // R2 hold-off: second request presented while ready is low
    a = '{1'b0, 5, 2, '0};
    b = '{1'b1, 5, 2, 8'h5A};
    c = '{1'b0, 5, 2, '0};
    exp_a = ref_mem[5][2];
    drive(a);
    @(posedge clk); @(negedge clk);
    check_p1(a);
    drive(b);
    @(posedge clk); @(negedge clk);
    check_p2(a);                        // R2: b not taken during development cycle
    @(posedge clk); @(negedge clk);
    check_p1(b);
    check_out(1'b1, exp_a);
    req_valid = 1'b0;
    ref_mem[5][2] = b.d;
    @(posedge clk); @(negedge clk);
    check_p2(b);
    drive(c);                           // R9 read straight after the write
    @(posedge clk); @(negedge clk);
    check_out(1'b0, '0);
    check_p1(c);
    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check_p2(c);
    @(posedge clk); @(negedge clk);
    check_out(1'b1, 8'h5A);
    check_idle();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule